// File: doc/BRIEF.md
# Shared-Memory Mailbox Aperture with Ownership Handoff

This block holds a 256-bit mailbox that two agents share: a requester and a responder. The requester sees the mailbox as eight 32-bit registers on a simple register bus. Each register is reached at a byte offset that is a multiple of four, from 0 up to 28. The responder reaches the same storage through its own port. It can read any register combinationally, write any register, and pulse a release strobe.

The top bit of the last register is the ownership flag. The requester fills the payload registers and writes the last register last. That final write passes the mailbox to the responder and rings a one-cycle doorbell. The responder leaves its reply in the last register and pulses release, which hands the mailbox back to the requester.

The requester polls the last register until the ownership bit drops. While the requester's reset input is high, every requester read returns all-ones and the storage is held at zero. Once that reset ends, the mailbox starts empty and is owned by the requester. The block does not interpret the payload or the header fields: the type in bits 2:0, the version in 5:3, the direction in bit 7, the status in 15:8 and the reset flag in bit 24 are stored as written.

Top module: `mailbox_aperture`

## Requirements
- R1: While the requester owns the mailbox, a requester write stores its data in the register selected by rq_addr[4:2]; rq_addr[1:0] are ignored. A later read returns the stored word one cycle after rq_rd_en, flagged by rq_rvalid.
- R2: A requester write to register 7 while the requester owns the mailbox stores bits 30:0 and forces bit 31 (owner) to 1, whatever value was written there. The owner output stays 1 until a release or a requester reset.
- R3: Requester writes while the responder owns the mailbox leave every register unchanged and set wr_err. wr_err stays set until a requester reset.
- R4: A requester read issued while req_rst is high returns 0xFFFFFFFF.
- R5: rs_doorbell is high for exactly the one cycle in which owner first reads 1 after a handoff.
- R6: rs_release clears bit 31 of register 7 and keeps bits 30:0. It has no effect while the requester already owns the mailbox.
- R7: The responder may write any register at any time, and rs_rdata shows the register selected by rs_rd_idx. A responder write to register 7 leaves bit 31 unchanged. A responder write beats a same-cycle requester write to the same register, and the requester write is then dropped without an error.
- R8: After reset, and after req_rst falls, all registers read zero, owner is 0 and wr_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| req_rst | input | 1 | Requester in reset (synchronous, active high) |
| rq_wr_en | input | 1 | Requester write strobe |
| rq_rd_en | input | 1 | Requester read strobe |
| rq_addr | input | 5 | Requester byte address |
| rq_wdata | input | 32 | Requester write data |
| rq_rdata | output | 32 | Requester read data |
| rq_rvalid | output | 1 | Read data valid, one cycle after rq_rd_en |
| rs_wr_en | input | 1 | Responder write strobe |
| rs_wr_idx | input | 3 | Responder write register index |
| rs_wdata | input | 32 | Responder write data |
| rs_rd_idx | input | 3 | Responder read register index |
| rs_rdata | output | 32 | Responder read data (combinational) |
| rs_release | input | 1 | Return ownership to the requester |
| rs_doorbell | output | 1 | One-cycle pulse on handoff to the responder |
| owner | output | 1 | 1 when the responder owns the mailbox |
| wr_err | output | 1 | Sticky flag for a blocked requester write |

## Verification
On every cycle the assertions check that:
- a final-register write by the requester passes ownership;
- ownership holds until a release;
- a release takes ownership back;
- the doorbell fires only on a fresh handoff;
- a blocked write raises the error flag;
- reads during requester reset give all-ones.

Only the bench's scenarios can show three further things:
- that stored payload words come back intact and that the low address bits are ignored;
- that a blocked write and a no-op release leave the contents unchanged;
- that a responder write beats a requester write to the same register.

// File: rtl/mailbox_aperture.sv
module mailbox_aperture #(
  parameter int DWORDS = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_rst,
  input  logic                          rq_wr_en,
  input  logic                          rq_rd_en,
  input  logic [ADDR_W-1:0]             rq_addr,
  input  logic [DATA_W-1:0]             rq_wdata,
  output logic [DATA_W-1:0]             rq_rdata,
  output logic                          rq_rvalid,
  input  logic                          rs_wr_en,
  input  logic [$clog2(DWORDS)-1:0]     rs_wr_idx,
  input  logic [DATA_W-1:0]             rs_wdata,
  input  logic [$clog2(DWORDS)-1:0]     rs_rd_idx,
  output logic [DATA_W-1:0]             rs_rdata,
  input  logic                          rs_release,
  output logic                          rs_doorbell,
  output logic                          owner,
  output logic                          wr_err
);
  localparam int IDX_W   = $clog2(DWORDS);
  localparam int LSB     = $clog2(DATA_W / 8);
  localparam int LAST    = DWORDS - 1;
  localparam int OWN_BIT = DATA_W - 1;

  logic [DATA_W-1:0] mem [DWORDS];
  logic [IDX_W-1:0]  rq_idx;
  logic              rq_ok, rq_blocked, rs_hit_last, handoff;

  assign rq_idx      = rq_addr[LSB +: IDX_W];
  assign owner       = mem[LAST][OWN_BIT];
  assign rs_rdata    = mem[rs_rd_idx];
  assign rq_ok       = rq_wr_en && !req_rst && !owner;
  assign rq_blocked  = rq_wr_en && !req_rst && owner;
  assign rs_hit_last = rs_wr_en && (rs_wr_idx == IDX_W'(LAST));
  assign handoff     = rq_ok && (rq_idx == IDX_W'(LAST)) && !rs_hit_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DWORDS; i++) mem[i] <= '0;
      rq_rdata    <= '0;
      rq_rvalid   <= 1'b0;
      rs_doorbell <= 1'b0;
      wr_err      <= 1'b0;
    end else begin
      rq_rvalid   <= rq_rd_en;
      rs_doorbell <= handoff;
      if (rq_rd_en) rq_rdata <= req_rst ? '1 : mem[rq_idx];
      if (req_rst) begin
        for (int i = 0; i < DWORDS; i++) mem[i] <= '0;
        wr_err <= 1'b0;
      end else begin
        if (rq_blocked) wr_err <= 1'b1;
        for (int i = 0; i < DWORDS; i++) begin
          if (rs_wr_en && rs_wr_idx == IDX_W'(i)) begin
            if (i == LAST)
              mem[i] <= {mem[i][OWN_BIT] & ~rs_release, rs_wdata[OWN_BIT-1:0]};
            else
              mem[i] <= rs_wdata;
          end else if (rq_ok && rq_idx == IDX_W'(i)) begin
            if (i == LAST)
              mem[i] <= {1'b1, rq_wdata[OWN_BIT-1:0]};
            else
              mem[i] <= rq_wdata;
          end else if (i == LAST && rs_release) begin
            mem[i][OWN_BIT] <= 1'b0;
          end
        end
      end
    end
  end
endmodule

module mailbox_aperture_chk #(
  parameter int DWORDS = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_rst,
  input logic                      rq_wr_en,
  input logic                      rq_rd_en,
  input logic [ADDR_W-1:0]         rq_addr,
  input logic [DATA_W-1:0]         rq_rdata,
  input logic                      rs_wr_en,
  input logic [$clog2(DWORDS)-1:0] rs_wr_idx,
  input logic                      rs_release,
  input logic                      rs_doorbell,
  input logic                      owner,
  input logic                      wr_err
);
  localparam int IDX_W = $clog2(DWORDS);
  localparam int LSB   = $clog2(DATA_W / 8);
  logic last_hit;
  assign last_hit = rq_addr[LSB +: IDX_W] == IDX_W'(DWORDS - 1);

  AST_HANDOFF_SETS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    rq_wr_en && !req_rst && !owner && last_hit && !(rs_wr_en && rs_wr_idx == IDX_W'(DWORDS - 1)) |=> owner); // R2
  AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    owner && !rs_release && !req_rst |=> owner); // R2
  AST_BLOCKED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    owner && rq_wr_en && !req_rst |=> wr_err); // R3
  AST_RESET_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    req_rst && rq_rd_en |=> rq_rdata == '1); // R4
  AST_DOORBELL_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    rs_doorbell |-> owner && !$past(owner)); // R5
  AST_RELEASE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    owner && rs_release |=> !owner); // R6
  AST_REQ_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    req_rst |=> !owner && !wr_err); // R8
endmodule

bind mailbox_aperture mailbox_aperture_chk #(.DWORDS(DWORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_rst(req_rst), .rq_wr_en(rq_wr_en), .rq_rd_en(rq_rd_en),
  .rq_addr(rq_addr), .rq_rdata(rq_rdata), .rs_wr_en(rs_wr_en), .rs_wr_idx(rs_wr_idx),
  .rs_release(rs_release), .rs_doorbell(rs_doorbell), .owner(owner), .wr_err(wr_err));

// File: tb/test_mailbox_aperture.sv
module test_mailbox_aperture;
  logic clk = 1'b0, rst_n = 1'b0, req_rst = 1'b0;
  logic rq_wr_en = 1'b0, rq_rd_en = 1'b0;
  logic [4:0] rq_addr = '0;
  logic [31:0] rq_wdata = '0, rq_rdata;
  logic rq_rvalid;
  logic rs_wr_en = 1'b0, rs_release = 1'b0;
  logic [2:0] rs_wr_idx = '0, rs_rd_idx = '0;
  logic [31:0] rs_wdata = '0, rs_rdata;
  logic rs_doorbell, owner, wr_err;

  int checks = 0, errors = 0;
  logic [31:0] em [8];
  logic [31:0] exp_q [$];
  string tag_q [$];

  always #5 clk = ~clk;

  mailbox_aperture i_mailbox_aperture (
    .clk(clk), .rst_n(rst_n), .req_rst(req_rst), .rq_wr_en(rq_wr_en), .rq_rd_en(rq_rd_en),
    .rq_addr(rq_addr), .rq_wdata(rq_wdata), .rq_rdata(rq_rdata), .rq_rvalid(rq_rvalid),
    .rs_wr_en(rs_wr_en), .rs_wr_idx(rs_wr_idx), .rs_wdata(rs_wdata), .rs_rd_idx(rs_rd_idx),
    .rs_rdata(rs_rdata), .rs_release(rs_release), .rs_doorbell(rs_doorbell),
    .owner(owner), .wr_err(wr_err));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rq_rvalid) begin
      if (exp_q.size() == 0) check("R1 unexpected read data", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rq_rdata, exp_q.pop_front());
    end
  end

  task automatic rq_write(int idx, logic [31:0] d, logic [1:0] sub);
    @(negedge clk);
    rq_wr_en = 1'b1; rq_addr = {idx[2:0], sub}; rq_wdata = d;
    @(negedge clk);
    rq_wr_en = 1'b0;
  endtask

  task automatic rq_read(int idx, string tag);
    @(negedge clk);
    rq_rd_en = 1'b1; rq_addr = {idx[2:0], 2'b00};
    exp_q.push_back(req_rst ? 32'hFFFF_FFFF : em[idx]);
    tag_q.push_back(tag);
    @(negedge clk);
    rq_rd_en = 1'b0;
  endtask

  task automatic rs_write(int idx, logic [31:0] d);
    @(negedge clk);
    rs_wr_en = 1'b1; rs_wr_idx = idx[2:0]; rs_wdata = d;
    @(negedge clk);
    rs_wr_en = 1'b0;
  endtask

  task automatic rs_rel();
    @(negedge clk);
    rs_release = 1'b1;
    @(negedge clk);
    rs_release = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) em[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R8 owner after reset", {31'b0, owner}, 32'h0);
    check("R8 wr_err after reset", {31'b0, wr_err}, 32'h0);
    check("R5 no doorbell after reset", {31'b0, rs_doorbell}, 32'h0);
    rq_read(0, "R8 dword0 zero"); rq_read(7, "R8 dword7 zero");

    for (int i = 0; i < 7; i++) begin
      em[i] = 32'hA5A5_0000 ^ (i * 32'h0101_1111);
      rq_write(i, em[i], 2'(i));
    end
    for (int i = 0; i < 7; i++) rq_read(i, "R1 payload readback");

    rq_write(7, 32'h0000_0001, 2'b00);
    em[7] = 32'h8000_0001;
    check("R2 owner after last write", {31'b0, owner}, 32'h1);
    check("R5 doorbell pulse", {31'b0, rs_doorbell}, 32'h1);
    @(negedge clk);
    check("R5 doorbell one cycle", {31'b0, rs_doorbell}, 32'h0);
    rq_read(7, "R2 owner bit forced");

    rq_write(2, 32'hDEAD_BEEF, 2'b00);
    check("R3 sticky error set", {31'b0, wr_err}, 32'h1);
    check("R5 no doorbell on blocked", {31'b0, rs_doorbell}, 32'h0);
    rq_read(2, "R3 blocked write ignored");

    rs_write(7, 32'h0000_0181);
    em[7] = 32'h8000_0181;
    check("R7 responder write keeps owner", {31'b0, owner}, 32'h1);
    rq_read(7, "R7 response header stored");
    rs_write(3, 32'h1234_5678);
    em[3] = 32'h1234_5678;
    rs_rd_idx = 3'd3; #1;
    check("R7 responder readback", rs_rdata, 32'h1234_5678);

    rs_rel();
    em[7] = 32'h0000_0181;
    check("R6 owner released", {31'b0, owner}, 32'h0);
    check("R3 error remains sticky", {31'b0, wr_err}, 32'h1);
    rq_read(7, "R6 payload kept on release");
    rs_rel();
    rq_read(7, "R6 release with no owner");

    @(negedge clk);
    rq_wr_en = 1'b1; rq_addr = {3'd4, 2'b00}; rq_wdata = 32'h1111_1111;
    rs_wr_en = 1'b1; rs_wr_idx = 3'd4; rs_wdata = 32'h2222_2222;
    @(negedge clk);
    rq_wr_en = 1'b0; rs_wr_en = 1'b0;
    em[4] = 32'h2222_2222;
    check("R7 no error on collision", {31'b0, wr_err}, 32'h1);
    rq_read(4, "R7 responder wins collision");

    rq_write(7, 32'hFFFF_FFFF, 2'b00);
    check("R2 owner set again", {31'b0, owner}, 32'h1);
    @(negedge clk);
    req_rst = 1'b1;
    @(negedge clk);
    rq_read(0, "R4 read in requester reset");
    rq_read(7, "R4 read in requester reset");
    req_rst = 1'b0;
    for (int i = 0; i < 8; i++) em[i] = '0;
    check("R8 owner after req reset", {31'b0, owner}, 32'h0);
    check("R8 error after req reset", {31'b0, wr_err}, 32'h0);
    rq_read(3, "R8 cleared after req reset");
    rq_read(7, "R8 cleared after req reset");

    repeat (4) @(negedge clk);
    check("R1 scoreboard drained", exp_q.size(), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule